// File: doc/BRIEF.md
# Battery Disconnect Switch Mode Controller

This block holds the power mode of a battery charger in a two-bit mode code written by the host. It drives the enable of an external switch that connects the battery to the system. It also drives the enable of the host serial interface and a request that puts the power converter into high impedance. The block allows low-power states only while no adapter is attached. Each state has its own way to return to normal operation.

A timed power-reset code turns the battery switch off for a fixed number of clock cycles and then returns the block to idle by itself. Entry from idle into any other code takes effect either on the next clock or after a fixed entry delay, chosen by a delay-select input. The reset pulse length and the entry delay are parameters counted in clock cycles. The accepted code can be read back on a status output.

Top module: `shipsw_ctrl`

## Requirements
- R1: After a synchronous reset, the status code is 00, the switch enable and the host-interface enable are 1, and the high-impedance request is 0.
- R2: From idle, with the delay select at 0 and no adapter, writing code 01 (shutdown) drives both the switch enable and the host-interface enable to 0 and shows 01 on the status from the next cycle.
- R3: In shutdown, only a rising edge of the adapter-present input returns the block to idle (status 00, both enables 1). Host writes and the wake pin have no effect.
- R4: From idle, with the delay select at 0 and no adapter, writing code 10 (ship) drives the switch enable to 0, keeps the host-interface enable at 1 and shows 10 on the status from the next cycle.
- R5: In ship mode, any of these returns the block to idle: a host write of 00, a rising edge of adapter-present, or the wake pin held low. The wake pin passes through two synchronizing flops, so idle follows on the third clock edge after the pin goes low.
- R6: A write of 01 or 10 while adapter-present is 1 is ignored: the status stays 00 and the switch stays on.
- R7: Code 11 (power reset) holds the switch enable at 0 for exactly PULSE_CYC cycles. After that the switch enable returns to 1 and the status returns to 00 without a host write.
- R8: The high-impedance request is 1 only while the power-reset pulse holds the switch off, and only while the VBUS-high input is 1.
- R9: With the delay select at 1, a write of 01, 10 or 11 from idle keeps the switch on for ENTRY_DLY_CYC cycles and then enters the requested state. The status shows the requested code during the wait.
- R10: A write of 00 during a pending entry cancels it and the block stays in idle. Any other write during a pending entry, and any write during a reset pulse, is ignored.
- R11: Whenever the switch enable is 0, the status shows a non-idle code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle strobe for a mode-code write |
| wr_mode | input | 2 | Code written: 00 idle, 01 shutdown, 10 ship, 11 power reset |
| dly_sel | input | 1 | 1 = delayed entry, 0 = entry on the next clock |
| adapter_present | input | 1 | Adapter attached; its rising edge counts as a plug-in |
| vbus_high | input | 1 | Input supply is above its threshold |
| wake_n | input | 1 | Asynchronous wake pin, active low |
| sw_en | output | 1 | Enable for the external battery disconnect switch |
| host_if_en | output | 1 | Enable for the host serial interface |
| hiz_req | output | 1 | Request for converter high impedance |
| mode_stat | output | 2 | Accepted mode code |

## Verification
On every cycle, assertions check the following:
- the host interface is off only in shutdown, and the switch is off only under a non-idle status;
- the high-impedance request appears only with the switch off and VBUS high;
- adapter-blocked writes leave the block idle;
- shutdown holds until a plug-in;
- writes that should have no effect are ignored.

Some behaviours can only be shown by the bench's scenarios, which run against a cycle-by-cycle reference model:
- the exact length of the reset pulse and of the entry delay;
- the three-edge latency of the wake pin;
- cancellation of a pending entry;
- the automatic return of the status to 00.

// File: rtl/shipsw_pkg.sv
`timescale 1ns/1ps
package shipsw_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE     = 2'b00,
        MODE_SHUTDOWN = 2'b01,
        MODE_SHIP     = 2'b10,
        MODE_RESET    = 2'b11
    } mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SHUTDOWN,
        ST_SHIP,
        ST_PULSE
    } state_t;

    typedef struct packed {
        logic sw_en;
        logic host_if_en;
        logic hiz_req;
    } drive_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_low_power(input mode_t m);
        return (m == MODE_SHUTDOWN) || (m == MODE_SHIP);
    endfunction

endpackage

// File: rtl/shipsw_inputs.sv
`timescale 1ns/1ps
module shipsw_inputs (
    input  logic clk,
    input  logic rst,
    input  logic wake_n,
    input  logic adapter_present,
    output logic wake_req,
    output logic plug_evt
);
    logic wake_s1, wake_s2;
    logic adp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_s1 <= 1'b1;
            wake_s2 <= 1'b1;
            adp_q   <= 1'b0;
        end else begin
            wake_s1 <= wake_n;
            wake_s2 <= wake_s1;
            adp_q   <= adapter_present;
        end
    end

    assign wake_req = ~wake_s2;
    assign plug_evt = adapter_present & ~adp_q;
endmodule

// File: rtl/shipsw_timer.sv
`timescale 1ns/1ps
module shipsw_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/shipsw_fsm.sv
`timescale 1ns/1ps
module shipsw_fsm
    import shipsw_pkg::*;
#(
    parameter int ENTRY_DLY_CYC = 8,
    parameter int PULSE_CYC     = 20,
    parameter int CNT_W         = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_mode,
    input  logic             dly_sel,
    input  logic             adapter_present,
    input  logic             vbus_high,
    input  logic             wake_req,
    input  logic             plug_evt,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sw_en,
    output logic             host_if_en,
    output logic             hiz_req,
    output logic [1:0]       mode_stat
);
    localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_DLY_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

    state_t state_q, state_d;
    mode_t  mode_q, mode_d;
    mode_t  req;
    drive_t drv;

    assign req = mode_t'(wr_mode);

    always_comb begin
        state_d  = state_q;
        mode_d   = mode_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en) begin
                    if (is_low_power(req)) begin
                        if (!adapter_present) begin
                            mode_d = req;
                            if (dly_sel) begin
                                state_d  = ST_ARMED;
                                tmr_load = 1'b1;
                                tmr_val  = ENTRY_LOAD;
                            end else begin
                                state_d = (req == MODE_SHUTDOWN) ? ST_SHUTDOWN : ST_SHIP;
                            end
                        end
                    end else if (req == MODE_RESET) begin
                        mode_d   = MODE_RESET;
                        tmr_load = 1'b1;
                        if (dly_sel) begin
                            state_d = ST_ARMED;
                            tmr_val = ENTRY_LOAD;
                        end else begin
                            state_d = ST_PULSE;
                            tmr_val = PULSE_LOAD;
                        end
                    end
                end
            end
            ST_ARMED: begin
                if (wr_en && req == MODE_IDLE) begin
                    state_d = ST_IDLE;
                    mode_d  = MODE_IDLE;
                end else if (tmr_zero) begin
                    unique case (mode_q)
                        MODE_SHUTDOWN: state_d = ST_SHUTDOWN;
                        MODE_SHIP:     state_d = ST_SHIP;
                        default: begin
                            state_d  = ST_PULSE;
                            tmr_load = 1'b1;
                            tmr_val  = PULSE_LOAD;
                        end
                    endcase
                end
            end
            ST_SHUTDOWN: begin
                if (plug_evt) begin
                    state_d = ST_IDLE;
                    mode_d  = MODE_IDLE;
                end
            end
            ST_SHIP: begin
                if (plug_evt || wake_req || (wr_en && req == MODE_IDLE)) begin
                    state_d = ST_IDLE;
                    mode_d  = MODE_IDLE;
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    mode_d  = MODE_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                mode_d  = MODE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_IDLE;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        drv.sw_en      = (state_q == ST_IDLE) || (state_q == ST_ARMED);
        drv.host_if_en = (state_q != ST_SHUTDOWN);
        drv.hiz_req    = (state_q == ST_PULSE) && vbus_high;
    end

    assign sw_en      = drv.sw_en;
    assign host_if_en = drv.host_if_en;
    assign hiz_req    = drv.hiz_req;
    assign mode_stat  = mode_q;

    AST_HOST_OFF_ONLY_SHUTDOWN: assert property (@(posedge clk) disable iff (rst)
        !host_if_en |-> (mode_q == MODE_SHUTDOWN)); // R3
    AST_SHUTDOWN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHUTDOWN && !plug_evt) |=> (!sw_en && !host_if_en)); // R3
    AST_SHIP_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && wr_en && req == MODE_SHIP && !adapter_present && !dly_sel)
        |=> (!sw_en && host_if_en)); // R4
    AST_SHIP_HOST_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIP && wr_en && req == MODE_IDLE) |=> (sw_en && mode_q == MODE_IDLE)); // R5
    AST_ADAPTER_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && wr_en && is_low_power(req) && adapter_present)
        |=> (sw_en && mode_q == MODE_IDLE)); // R6
    AST_PULSE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && tmr_zero) |=> (sw_en && mode_q == MODE_IDLE)); // R7
    AST_HIZ_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        hiz_req |-> (!sw_en && vbus_high && mode_q == MODE_RESET)); // R8
    AST_PULSE_IGNORES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && !tmr_zero && wr_en) |=> (!sw_en && $stable(mode_q))); // R10
    AST_OFF_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !sw_en |-> (mode_q != MODE_IDLE)); // R11
endmodule

// File: rtl/shipsw_ctrl.sv
`timescale 1ns/1ps
module shipsw_ctrl
    import shipsw_pkg::*;
#(
    parameter int ENTRY_DLY_CYC = 500_000,
    parameter int PULSE_CYC     = 17_500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       dly_sel,
    input  logic       adapter_present,
    input  logic       vbus_high,
    input  logic       wake_n,
    output logic       sw_en,
    output logic       host_if_en,
    output logic       hiz_req,
    output logic [1:0] mode_stat
);
    localparam int CNT_W = $clog2(max2(ENTRY_DLY_CYC, PULSE_CYC) + 1);

    logic             wake_req;
    logic             plug_evt;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    shipsw_inputs u_inputs (
        .clk             (clk),
        .rst             (rst),
        .wake_n          (wake_n),
        .adapter_present (adapter_present),
        .wake_req        (wake_req),
        .plug_evt        (plug_evt)
    );

    shipsw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    shipsw_fsm #(
        .ENTRY_DLY_CYC (ENTRY_DLY_CYC),
        .PULSE_CYC     (PULSE_CYC),
        .CNT_W         (CNT_W)
    ) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .wr_en           (wr_en),
        .wr_mode         (wr_mode),
        .dly_sel         (dly_sel),
        .adapter_present (adapter_present),
        .vbus_high       (vbus_high),
        .wake_req        (wake_req),
        .plug_evt        (plug_evt),
        .tmr_zero        (tmr_zero),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .sw_en           (sw_en),
        .host_if_en      (host_if_en),
        .hiz_req         (hiz_req),
        .mode_stat       (mode_stat)
    );
endmodule

// File: tb/tb_shipsw_ctrl.sv
`timescale 1ns/1ps
module tb_shipsw_ctrl;
    localparam int ENTRY = 8;
    localparam int PULSE = 20;
    localparam int S_IDLE = 0, S_ARM = 1, S_SD = 2, S_SHIP = 3, S_PULSE = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic       dly_sel = 1'b0;
    logic       adapter_present = 1'b0;
    logic       vbus_high = 1'b0;
    logic       wake_n = 1'b1;
    logic       sw_en, host_if_en, hiz_req;
    logic [1:0] mode_stat;

    int n_chk = 0;
    int n_fail = 0;
    bit started = 1'b0;
    bit finished = 1'b0;
    string tag = "R1";

    int ms = S_IDLE;
    int mm = 0;
    int rem = 0;
    bit w1 = 1'b1, w2 = 1'b1, ap = 1'b0;

    always #10 clk = ~clk;

    shipsw_ctrl #(.ENTRY_DLY_CYC(ENTRY), .PULSE_CYC(PULSE)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .dly_sel(dly_sel),
        .adapter_present(adapter_present), .vbus_high(vbus_high), .wake_n(wake_n),
        .sw_en(sw_en), .host_if_en(host_if_en), .hiz_req(hiz_req), .mode_stat(mode_stat)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            ms = S_IDLE; mm = 0; rem = 0; w1 = 1'b1; w2 = 1'b1; ap = 1'b0;
        end else begin
            bit plug, wk;
            int nxt, nm;
            plug = adapter_present && !ap;
            wk   = !w2;
            nxt  = ms;
            nm   = mm;
            case (ms)
                S_IDLE: if (wr_en) begin
                    if (wr_mode == 1 || wr_mode == 2) begin
                        if (!adapter_present) begin
                            nm = wr_mode;
                            if (dly_sel) begin nxt = S_ARM; rem = ENTRY; end
                            else nxt = (wr_mode == 1) ? S_SD : S_SHIP;
                        end
                    end else if (wr_mode == 3) begin
                        nm = 3;
                        if (dly_sel) begin nxt = S_ARM; rem = ENTRY; end
                        else begin nxt = S_PULSE; rem = PULSE; end
                    end
                end
                S_ARM: begin
                    if (wr_en && wr_mode == 0) begin nxt = S_IDLE; nm = 0; end
                    else if (rem == 1) begin
                        if (mm == 1) nxt = S_SD;
                        else if (mm == 2) nxt = S_SHIP;
                        else begin nxt = S_PULSE; rem = PULSE; end
                    end else rem--;
                end
                S_SD: if (plug) begin nxt = S_IDLE; nm = 0; end
                S_SHIP: if (plug || wk || (wr_en && wr_mode == 0)) begin nxt = S_IDLE; nm = 0; end
                default: begin
                    if (rem == 1) begin nxt = S_IDLE; nm = 0; end
                    else rem--;
                end
            endcase
            ms = nxt; mm = nm;
            w2 = w1; w1 = wake_n; ap = adapter_present;
        end
    end

    // compare every cycle, mid-way between edges
    always begin
        @(negedge clk);
        #5;
        if (started && !rst && !finished) begin
            bit e_sw, e_host, e_hiz;
            e_sw   = (ms == S_IDLE) || (ms == S_ARM);
            e_host = (ms != S_SD);
            e_hiz  = (ms == S_PULSE) && vbus_high;
            n_chk++;
            if (sw_en !== e_sw || host_if_en !== e_host || hiz_req !== e_hiz || mode_stat !== 2'(mm)) begin
                n_fail++;
                $display("FAIL %s model: actual sw=%b host=%b hiz=%b mode=%0d expected sw=%b host=%b hiz=%b mode=%0d",
                         tag, sw_en, host_if_en, hiz_req, mode_stat, e_sw, e_host, e_hiz, mm);
            end
        end
    end

    task automatic chk(input bit ok, input string t, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] m);
        @(negedge clk); wr_en = 1'b1; wr_mode = m;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int outs();
        return {sw_en, host_if_en, hiz_req, mode_stat};
    endfunction

    initial begin
        #(20 * 50000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        cyc(3); rst = 1'b0; started = 1'b1;
        #5;
        chk(outs() == 5'b11000, "R1 reset state", outs(), 5'b11000);

        tag = "R2"; wr(2'b01); #5;
        chk(outs() == 5'b00001, "R2 shutdown entry", outs(), 5'b00001);
        tag = "R3"; wr(2'b00); wake_n = 1'b0; cyc(5); wake_n = 1'b1; cyc(2); #5;
        chk(outs() == 5'b00001, "R3 shutdown ignores write and wake", outs(), 5'b00001);
        @(negedge clk); adapter_present = 1'b1; @(negedge clk); #5;
        chk(outs() == 5'b11000, "R3 plug-in wakes", outs(), 5'b11000);

        tag = "R6"; wr(2'b10); #5;
        chk(mode_stat == 2'b00 && sw_en, "R6 ship blocked", mode_stat, 0);
        wr(2'b01); #5;
        chk(mode_stat == 2'b00 && sw_en, "R6 shutdown blocked", mode_stat, 0);
        @(negedge clk); adapter_present = 1'b0;

        tag = "R4"; wr(2'b10); #5;
        chk(outs() == 5'b01010, "R4 ship entry", outs(), 5'b01010);
        tag = "R5"; wr(2'b00); #5;
        chk(outs() == 5'b11000, "R5 host write wakes ship", outs(), 5'b11000);
        wr(2'b10);
        @(negedge clk); wake_n = 1'b0;
        cyc(2); #5;
        chk(sw_en == 1'b0, "R5 wake latency not yet", sw_en, 0);
        @(negedge clk); #5;
        chk(sw_en == 1'b1 && mode_stat == 2'b00, "R5 wake pin wakes ship", sw_en, 1);
        @(negedge clk); wake_n = 1'b1; cyc(3);
        wr(2'b10); cyc(2);
        @(negedge clk); adapter_present = 1'b1; @(negedge clk); #5;
        chk(sw_en == 1'b1 && mode_stat == 2'b00, "R5 plug-in wakes ship", sw_en, 1);
        @(negedge clk); adapter_present = 1'b0;

        tag = "R7"; vbus_high = 1'b1; wr(2'b11); #5;
        chk(hiz_req == 1'b1, "R8 hiz with vbus high", hiz_req, 1);
        n = 0;
        while (!sw_en && n < 100) begin n++; @(negedge clk); #5; end
        chk(n == PULSE, "R7 pulse length", n, PULSE);
        chk(mode_stat == 2'b00, "R7 auto return to idle", mode_stat, 0);
        tag = "R8"; cyc(1); vbus_high = 1'b0; wr(2'b11); #5;
        chk(hiz_req == 1'b0 && !sw_en, "R8 no hiz with vbus low", hiz_req, 0);
        tag = "R10"; wr(2'b00); wr(2'b10); #5;
        chk(!sw_en && mode_stat == 2'b11, "R10 writes ignored in pulse", mode_stat, 3);
        cyc(PULSE); #5;
        chk(sw_en && mode_stat == 2'b00, "R7 back to idle", mode_stat, 0);

        tag = "R9"; @(negedge clk); dly_sel = 1'b1; wr(2'b10); #5;
        chk(mode_stat == 2'b10, "R9 status shows pending code", mode_stat, 2);
        n = 0;
        while (sw_en && n < 100) begin n++; @(negedge clk); #5; end
        chk(n == ENTRY, "R9 entry delay length", n, ENTRY);
        chk(host_if_en && mode_stat == 2'b10, "R9 ship after delay", mode_stat, 2);
        wr(2'b00);

        tag = "R10"; wr(2'b01); cyc(2); wr(2'b00); cyc(ENTRY + 2); #5;
        chk(sw_en && host_if_en && mode_stat == 2'b00, "R10 cancel pending entry", mode_stat, 0);
        wr(2'b01); cyc(1); wr(2'b10); cyc(ENTRY); #5;
        chk(!host_if_en && mode_stat == 2'b01, "R10 write ignored while pending", mode_stat, 1);
        @(negedge clk); adapter_present = 1'b1; cyc(2); adapter_present = 1'b0;

        tag = "R9"; wr(2'b11); cyc(ENTRY - 1); #5;
        chk(sw_en && mode_stat == 2'b11, "R9 delayed reset still on", sw_en, 1);
        @(negedge clk); #5;
        chk(!sw_en, "R9 delayed reset pulse starts", sw_en, 0);
        tag = "R11"; cyc(PULSE + 2); #5;
        chk(sw_en && mode_stat == 2'b00, "R11 idle after delayed reset", mode_stat, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule